// File: doc/BRIEF.md
# Multiprocessor UART Receiver with Address Filtering

This block is the receive half of an asynchronous serial port that carries 9-bit frames. Each frame has a low start bit, eight data bits sent least significant bit first, a ninth bit, and a stop bit. The block watches a serial input line that is oversampled 16 times per bit. The oversample tick comes from outside, and the block only advances on cycles where that tick is high. A start bit is accepted only if it is still low at mid-bit. Every later bit is sampled once per bit time, at the same phase.

Software can turn on hardware address filtering for multiprocessor links. While filtering is on, the block accepts a completed frame only if its ninth bit is 1 and its byte matches one of two addresses:
- a masked individual address;
- a broadcast address formed as the bitwise OR of the individual address and its mask.

An accepted frame loads the received byte and ninth bit and raises the receive-ready flag. A frame whose stop bit reads low raises a framing-error flag instead. That flag stays set until software clears it.

Top module: `mp_uart_rx`

## Requirements
- R1: After reset, the ready flag, framing flag, received byte, ninth bit, view bit, individual address and mask all read 0. With the reset mask of 0, filtering accepts any byte that carries a ninth bit of 1.
- R2: Bits are sampled every 16 ticks after start confirmation, least significant data bit first, then the ninth bit, then the stop bit. When the stop bit is high and the frame is accepted, the byte and ninth bit are loaded and the ready flag is set. With filtering off, every frame with a high stop bit is accepted.
- R3: A low level is taken as a start bit only if the line is still low on the 8th tick after the tick that first saw it low. Otherwise the receiver returns to idle, and no flag or data changes.
- R4: With filtering on (control bit 5 set), a frame whose ninth bit is 0 leaves the ready flag and received data unchanged.
- R5: Individual match: for each bit where the mask is 1, the received bit must equal the address bit; mask bits of 0 are don't care. Example: address 1111_0001 with mask 1111_1010 accepts 1111_0X0X, and address 1111_0011 with mask 1111_1001 accepts 1111_0XX1.
- R6: Broadcast match: the byte is accepted when it has a 1 at every position where (address OR mask) has a 1.
- R7: A low stop bit sets the framing flag. It leaves the ready flag and data unchanged, and a later frame with a valid stop bit does not clear the flag.
- R8: Software writes the control register at select 2. Bit 0 gives the new ready flag. When bit 6 of the written byte is 1, bit 7 gives the new framing flag.
- R9: The view bit shows the framing flag while the stored view-select (control bit 6) is 1. Otherwise it shows a stored mode bit, which is written from bit 7 only when the written bit 6 is 0. Such a write leaves the framing flag unchanged.
- R10: When a hardware flag set and a software clear of that flag fall in the same cycle, the flag ends set.
- R11: Nothing advances on cycles where the oversample tick is low. A frame sent while ticks are stopped has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| os_tick | input | 1 | Oversample enable, 16 per bit time |
| rxd | input | 1 | Serial receive line, idle high |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 address, 1 mask, 2 control, 3 ignored |
| reg_wdata | input | 8 | Register write data |
| rx_byte | output | 8 | Last accepted data byte |
| rx_bit9 | output | 1 | Ninth bit of the last accepted frame |
| ri | output | 1 | Receive-ready flag |
| fe | output | 1 | Sticky framing-error flag |
| ctrl_top | output | 1 | Control view bit: framing flag or mode bit |

## Verification
A flag can be set by a completed frame and written by software in the same clock; that collision is the case of interest here. The bench provokes it by watching its own model for the cycle in which a frame's result is pending. It then issues a control write that clears the ready flag, or the framing flag, on exactly that edge. It judges the outcome by requiring the flag to read 1 afterwards. Every other clock is compared against the behavioural model, so any cycle shift in where the write and the set meet is also reported.

// File: rtl/mp_uart_rx_pkg.sv
package mp_uart_rx_pkg;

    localparam int BYTE_W = 8;

    localparam logic [1:0] SEL_ADDR = 2'd0;
    localparam logic [1:0] SEL_MASK = 2'd1;
    localparam logic [1:0] SEL_CTRL = 2'd2;

    localparam int CB_RI    = 0;
    localparam int CB_FILT  = 5;
    localparam int CB_VSEL  = 6;
    localparam int CB_TOP   = 7;

    typedef enum logic [1:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_STOP
    } rx_state_e;

    typedef struct packed {
        logic [BYTE_W-1:0] data;
        logic              bit9;
        logic              stop_ok;
    } rx_frame_t;

    // masked individual comparison: only mask-1 positions must agree
    function automatic logic given_hit(input logic [BYTE_W-1:0] rx,
                                       input logic [BYTE_W-1:0] own,
                                       input logic [BYTE_W-1:0] msk);
        return ((rx ^ own) & msk) == '0;
    endfunction

    // broadcast: every 1 of (own | msk) must be 1 in the byte
    function automatic logic bcast_hit(input logic [BYTE_W-1:0] rx,
                                       input logic [BYTE_W-1:0] own,
                                       input logic [BYTE_W-1:0] msk);
        return ((~rx) & (own | msk)) == '0;
    endfunction

endpackage

// File: rtl/mp_rx_sync.sv
module mp_rx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] q;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst) q <= '1;
                else     q <= din;
            end
        end else begin : g_chain
            always_ff @(posedge clk) begin
                if (rst) q <= '1;
                else     q <= {q[STAGES-2:0], din};
            end
        end
    endgenerate

    assign dout = q[STAGES-1];
endmodule

// File: rtl/mp_rx_framer.sv
module mp_rx_framer
    import mp_uart_rx_pkg::*;
#(
    parameter int OSR = 16
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      tick,
    input  logic      rxs,
    output logic      done,
    output rx_frame_t frame
);
    localparam int CNT_W     = $clog2(OSR);
    localparam int HALF_LAST = OSR / 2 - 1;
    localparam int FULL_LAST = OSR - 1;
    localparam int NBITS     = BYTE_W + 1;
    localparam int IDX_W     = $clog2(NBITS + 1);

    rx_state_e        st;
    logic [CNT_W-1:0] cnt;
    logic [IDX_W-1:0] idx;
    logic [NBITS-1:0] sh;

    always_ff @(posedge clk) begin
        if (rst) begin
            st    <= RX_IDLE;
            cnt   <= '0;
            idx   <= '0;
            sh    <= '0;
            done  <= 1'b0;
            frame <= '0;
        end else begin
            done <= 1'b0;
            if (tick) begin
                unique case (st)
                    RX_IDLE: begin
                        if (!rxs) begin
                            st  <= RX_START;
                            cnt <= '0;
                        end
                    end
                    RX_START: begin
                        if (cnt == CNT_W'(HALF_LAST)) begin
                            cnt <= '0;
                            idx <= '0;
                            st  <= rxs ? RX_IDLE : RX_DATA;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    RX_DATA: begin
                        if (cnt == CNT_W'(FULL_LAST)) begin
                            cnt <= '0;
                            sh  <= {rxs, sh[NBITS-1:1]};
                            if (idx == IDX_W'(NBITS - 1)) st <= RX_STOP;
                            else                          idx <= idx + 1'b1;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    RX_STOP: begin
                        if (cnt == CNT_W'(FULL_LAST)) begin
                            cnt           <= '0;
                            st            <= RX_IDLE;
                            done          <= 1'b1;
                            frame.data    <= sh[BYTE_W-1:0];
                            frame.bit9    <= sh[NBITS-1];
                            frame.stop_ok <= rxs;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                endcase
            end
        end
    end
endmodule

// File: rtl/mp_addr_filter.sv
module mp_addr_filter
    import mp_uart_rx_pkg::*;
(
    input  logic              filt_en,
    input  logic [BYTE_W-1:0] own_addr,
    input  logic [BYTE_W-1:0] addr_mask,
    input  logic [BYTE_W-1:0] rx_data,
    input  logic              rx_bit9,
    output logic              accept
);
    logic hit_given;
    logic hit_bcast;

    always_comb begin
        hit_given = given_hit(rx_data, own_addr, addr_mask);
        hit_bcast = bcast_hit(rx_data, own_addr, addr_mask);
        accept    = !filt_en || (rx_bit9 && (hit_given || hit_bcast));
    end
endmodule

// File: rtl/mp_rx_regs.sv
module mp_rx_regs
    import mp_uart_rx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [1:0]        sel,
    input  logic [BYTE_W-1:0] wdata,
    input  logic              done,
    input  rx_frame_t         frame,
    input  logic              accept,
    output logic [BYTE_W-1:0] own_addr,
    output logic [BYTE_W-1:0] addr_mask,
    output logic              filt_en,
    output logic              ri,
    output logic              fe,
    output logic [BYTE_W-1:0] rx_byte,
    output logic              rx_bit9,
    output logic              ctrl_top
);
    logic vsel;
    logic mode_top;
    logic ctrl_wr;
    logic ri_n;
    logic fe_n;
    logic load;
    logic unused_wbits;

    assign unused_wbits = ^wdata[CB_FILT-1:CB_RI+1];

    always_comb begin
        ctrl_wr = we && (sel == SEL_CTRL);
        ri_n    = ri;
        fe_n    = fe;
        load    = 1'b0;
        if (ctrl_wr) begin
            ri_n = wdata[CB_RI];
            if (wdata[CB_VSEL]) fe_n = wdata[CB_TOP];
        end
        // hardware set is applied last so it wins a same-cycle clear
        if (done) begin
            if (frame.stop_ok) begin
                if (accept) begin
                    ri_n = 1'b1;
                    load = 1'b1;
                end
            end else begin
                fe_n = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            own_addr  <= '0;
            addr_mask <= '0;
            filt_en   <= 1'b0;
            vsel      <= 1'b0;
            mode_top  <= 1'b0;
            ri        <= 1'b0;
            fe        <= 1'b0;
            rx_byte   <= '0;
            rx_bit9   <= 1'b0;
        end else begin
            ri <= ri_n;
            fe <= fe_n;
            if (we && sel == SEL_ADDR) own_addr  <= wdata;
            if (we && sel == SEL_MASK) addr_mask <= wdata;
            if (ctrl_wr) begin
                filt_en <= wdata[CB_FILT];
                vsel    <= wdata[CB_VSEL];
                if (!wdata[CB_VSEL]) mode_top <= wdata[CB_TOP];
            end
            if (load) begin
                rx_byte <= frame.data;
                rx_bit9 <= frame.bit9;
            end
        end
    end

    assign ctrl_top = vsel ? fe : mode_top;
endmodule

// File: rtl/mp_uart_rx.sv
module mp_uart_rx
    import mp_uart_rx_pkg::*;
#(
    parameter int OSR         = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              os_tick,
    input  logic              rxd,
    input  logic              reg_we,
    input  logic [1:0]        reg_sel,
    input  logic [BYTE_W-1:0] reg_wdata,
    output logic [BYTE_W-1:0] rx_byte,
    output logic              rx_bit9,
    output logic              ri,
    output logic              fe,
    output logic              ctrl_top
);
    logic              rxs;
    logic              frame_done;
    rx_frame_t         frame;
    logic              accept;
    logic              filt_en;
    logic [BYTE_W-1:0] own_addr;
    logic [BYTE_W-1:0] addr_mask;

    mp_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  (rxd),
        .dout (rxs)
    );

    mp_rx_framer #(.OSR(OSR)) u_framer (
        .clk   (clk),
        .rst   (rst),
        .tick  (os_tick),
        .rxs   (rxs),
        .done  (frame_done),
        .frame (frame)
    );

    mp_addr_filter u_filter (
        .filt_en   (filt_en),
        .own_addr  (own_addr),
        .addr_mask (addr_mask),
        .rx_data   (frame.data),
        .rx_bit9   (frame.bit9),
        .accept    (accept)
    );

    mp_rx_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .we        (reg_we),
        .sel       (reg_sel),
        .wdata     (reg_wdata),
        .done      (frame_done),
        .frame     (frame),
        .accept    (accept),
        .own_addr  (own_addr),
        .addr_mask (addr_mask),
        .filt_en   (filt_en),
        .ri        (ri),
        .fe        (fe),
        .rx_byte   (rx_byte),
        .rx_bit9   (rx_bit9),
        .ctrl_top  (ctrl_top)
    );
endmodule

// File: rtl/mp_uart_rx_chk.sv
module mp_uart_rx_chk (
    input logic       clk,
    input logic       rst,
    input logic       ctrl_wr,
    input logic       wr_ri,
    input logic       wr_vsel,
    input logic       wr_top,
    input logic       done,
    input logic       stop_ok,
    input logic       bit9,
    input logic       filt_en,
    input logic       ri,
    input logic       fe,
    input logic [7:0] rx_byte
);
    // R1
    first_after_reset_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!ri && !fe));

    // R7
    fe_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(fe) |-> $past(ctrl_wr && wr_vsel && !wr_top));

    // R2
    ri_source_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(ri) |-> $past(done || (ctrl_wr && wr_ri)));

    // R4
    filter_gate_chk: assert property (@(posedge clk) disable iff (rst)
        ($rose(ri) && !$past(ctrl_wr)) |-> $past(!filt_en || bit9));

    // R2
    data_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(rx_byte) |-> ri);

    // R10
    set_wins_chk: assert property (@(posedge clk) disable iff (rst)
        (done && !stop_ok) |=> fe);
endmodule

bind mp_uart_rx mp_uart_rx_chk i_chk (
    .clk     (clk),
    .rst     (rst),
    .ctrl_wr (reg_we && reg_sel == 2'd2),
    .wr_ri   (reg_wdata[0]),
    .wr_vsel (reg_wdata[6]),
    .wr_top  (reg_wdata[7]),
    .done    (frame_done),
    .stop_ok (frame.stop_ok),
    .bit9    (frame.bit9),
    .filt_en (filt_en),
    .ri      (ri),
    .fe      (fe),
    .rx_byte (rx_byte)
);

// File: tb/test_mp_uart_rx.sv
module test_mp_uart_rx;
    localparam int CLK_PERIOD = 10;
    localparam int OSR        = 16;
    localparam int TICK_DIV   = 2;
    localparam int BIT_CLKS   = OSR * TICK_DIV;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       os_tick = 1'b0;
    logic       rxd = 1'b1;
    logic       reg_we = 1'b0;
    logic [1:0] reg_sel = 2'd0;
    logic [7:0] reg_wdata = 8'd0;
    logic [7:0] rx_byte;
    logic       rx_bit9;
    logic       ri;
    logic       fe;
    logic       ctrl_top;

    int checks = 0;
    int errors = 0;
    bit tick_run = 1'b1;
    bit finished = 1'b0;
    int tdiv = 0;

    mp_uart_rx #(.OSR(OSR), .SYNC_STAGES(2)) i_mp_uart_rx (
        .clk       (clk),
        .rst       (rst),
        .os_tick   (os_tick),
        .rxd       (rxd),
        .reg_we    (reg_we),
        .reg_sel   (reg_sel),
        .reg_wdata (reg_wdata),
        .rx_byte   (rx_byte),
        .rx_bit9   (rx_bit9),
        .ri        (ri),
        .fe        (fe),
        .ctrl_top  (ctrl_top)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    always @(negedge clk) begin
        if (tick_run) begin
            tdiv    = (tdiv + 1) % TICK_DIV;
            os_tick = (tdiv == 0);
        end else begin
            os_tick = 1'b0;
        end
    end

    // ---------------- behavioural reference model ----------------
    int m_h1, m_h2, m_state, m_cnt, m_nb, m_word;
    int m_pend, m_pdata, m_pb9, m_pstop;
    int m_own, m_msk, m_filt, m_vsel, m_mode;
    int exp_ri, exp_fe, exp_byte, exp_b9;

    function automatic int match_ok(int d, int own, int msk);
        int g, b;
        g = 1;
        b = 1;
        for (int i = 0; i < 8; i++) begin
            if (((msk >> i) & 1) == 1 && ((d >> i) & 1) != ((own >> i) & 1)) g = 0;
            if ((((own | msk) >> i) & 1) == 1 && ((d >> i) & 1) == 0) b = 0;
        end
        return (g == 1 || b == 1) ? 1 : 0;
    endfunction

    always @(posedge clk) begin
        int s, acc;
        if (rst) begin
            m_h1 = 1; m_h2 = 1; m_state = 0; m_cnt = 0; m_nb = 0; m_word = 0;
            m_pend = 0; m_pdata = 0; m_pb9 = 0; m_pstop = 0;
            m_own = 0; m_msk = 0; m_filt = 0; m_vsel = 0; m_mode = 0;
            exp_ri = 0; exp_fe = 0; exp_byte = 0; exp_b9 = 0;
        end else begin
            s    = m_h2;
            m_h2 = m_h1;
            m_h1 = rxd;
            acc  = 0;
            if (m_pend == 1 && m_pstop == 1)
                acc = (m_filt == 0 || (m_pb9 == 1 && match_ok(m_pdata, m_own, m_msk) == 1)) ? 1 : 0;
            if (reg_we) begin
                if (reg_sel == 2'd0) m_own = reg_wdata;
                else if (reg_sel == 2'd1) m_msk = reg_wdata;
                else if (reg_sel == 2'd2) begin
                    m_filt = reg_wdata[5];
                    m_vsel = reg_wdata[6];
                    if (!reg_wdata[6]) m_mode = reg_wdata[7];
                    exp_ri = reg_wdata[0];
                    if (reg_wdata[6]) exp_fe = reg_wdata[7];
                end
            end
            if (m_pend == 1) begin
                if (m_pstop == 1) begin
                    if (acc == 1) begin
                        exp_ri = 1; exp_byte = m_pdata; exp_b9 = m_pb9;
                    end
                end else begin
                    exp_fe = 1;
                end
            end
            m_pend = 0;
            if (os_tick) begin
                case (m_state)
                    0: if (s == 0) begin m_state = 1; m_cnt = 0; end
                    1: begin
                        m_cnt++;
                        if (m_cnt == OSR / 2) begin
                            m_cnt = 0; m_nb = 0; m_word = 0;
                            m_state = (s == 1) ? 0 : 2;
                        end
                    end
                    2: begin
                        m_cnt++;
                        if (m_cnt == OSR) begin
                            m_cnt = 0;
                            m_word = m_word | (s << m_nb);
                            m_nb++;
                            if (m_nb == 9) m_state = 3;
                        end
                    end
                    default: begin
                        m_cnt++;
                        if (m_cnt == OSR) begin
                            m_cnt = 0; m_state = 0; m_pend = 1;
                            m_pdata = m_word & 255; m_pb9 = (m_word >> 8) & 1; m_pstop = s;
                        end
                    end
                endcase
            end
        end
    end

    // per-clock comparison against the model
    always @(negedge clk) begin
        if (!rst && !finished) begin
            checks++;
            if (ri !== exp_ri[0] || fe !== exp_fe[0] || rx_byte !== exp_byte[7:0] ||
                rx_bit9 !== exp_b9[0] || ctrl_top !== ((m_vsel == 1) ? exp_fe[0] : m_mode[0])) begin
                errors++;
                $display("FAIL R2 per-cycle t=%0t ri/fe/byte/b9/top act=%0b/%0b/%02h/%0b/%0b exp=%0d/%0d/%02h/%0d/%0d",
                         $time, ri, fe, rx_byte, rx_bit9, ctrl_top, exp_ri, exp_fe, exp_byte, exp_b9,
                         (m_vsel == 1) ? exp_fe : m_mode);
            end
        end
    end

    // ---------------- tasks ----------------
    task automatic chk(input string req, input int act, input int expv);
        checks++;
        if (act != expv) begin
            errors++;
            $display("FAIL %s act=%0h exp=%0h", req, act, expv);
        end
    endtask

    task automatic wr(input logic [1:0] sel, input logic [7:0] d);
        reg_we = 1'b1; reg_sel = sel; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
        @(negedge clk);
    endtask

    task automatic hold(input logic v, input int n);
        rxd = v;
        repeat (n) @(negedge clk);
    endtask

    task automatic send_frame(input logic [7:0] d, input logic b9, input logic stop_good);
        hold(1'b0, BIT_CLKS);
        for (int i = 0; i < 8; i++) hold(d[i], BIT_CLKS);
        hold(b9, BIT_CLKS);
        if (stop_good) hold(1'b1, BIT_CLKS);
        else           hold(1'b0, 12 * TICK_DIV);
        hold(1'b1, 3 * BIT_CLKS);
    endtask

    task automatic write_at_pending(input logic [7:0] d);
        do @(negedge clk); while (m_pend == 0);
        reg_we = 1'b1; reg_sel = 2'd2; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        chk("R1 ri", ri, 0);
        chk("R1 fe", fe, 0);
        chk("R1 byte", rx_byte, 0);
        chk("R1 bit9", rx_bit9, 0);
        chk("R1 top", ctrl_top, 0);

        // R2 unfiltered reception
        send_frame(8'hA5, 1'b0, 1'b1);
        chk("R2 ri", ri, 1);
        chk("R2 byte", rx_byte, 8'hA5);
        chk("R2 bit9", rx_bit9, 0);
        wr(2'd2, 8'h00);
        chk("R8 ri clear", ri, 0);
        send_frame(8'h5A, 1'b1, 1'b1);
        chk("R2 byte2", rx_byte, 8'h5A);
        chk("R2 bit9 2", rx_bit9, 1);

        // R1 reset mask accepts any ninth-bit-1 byte
        wr(2'd2, 8'h20);
        send_frame(8'h3C, 1'b1, 1'b1);
        chk("R1 mask zero ri", ri, 1);
        chk("R1 mask zero byte", rx_byte, 8'h3C);
        wr(2'd2, 8'h20);

        // R4 ninth bit 0 ignored
        send_frame(8'h77, 1'b0, 1'b1);
        chk("R4 ri", ri, 0);
        chk("R4 byte", rx_byte, 8'h3C);

        // R5 first address/mask pair
        wr(2'd0, 8'hF1);
        wr(2'd1, 8'hFA);
        send_frame(8'hF4, 1'b1, 1'b1);
        chk("R5 hit ri", ri, 1);
        chk("R5 hit byte", rx_byte, 8'hF4);
        wr(2'd2, 8'h20);
        send_frame(8'hF4, 1'b0, 1'b1);
        chk("R4 addr ninth0", ri, 0);
        send_frame(8'hF2, 1'b1, 1'b1);
        chk("R5 miss ri", ri, 0);
        chk("R5 miss byte", rx_byte, 8'hF4);

        // R6 broadcast
        send_frame(8'hFF, 1'b1, 1'b1);
        chk("R6 ff ri", ri, 1);
        chk("R6 ff byte", rx_byte, 8'hFF);
        wr(2'd2, 8'h20);
        send_frame(8'hFB, 1'b1, 1'b1);
        chk("R6 fb ri", ri, 1);
        chk("R6 fb byte", rx_byte, 8'hFB);
        wr(2'd2, 8'h20);

        // R5 second address/mask pair
        wr(2'd0, 8'hF3);
        wr(2'd1, 8'hF9);
        send_frame(8'hF7, 1'b1, 1'b1);
        chk("R5 pair2 hit", rx_byte, 8'hF7);
        wr(2'd2, 8'h20);
        send_frame(8'hF6, 1'b1, 1'b1);
        chk("R5 pair2 miss ri", ri, 0);
        chk("R5 pair2 miss byte", rx_byte, 8'hF7);

        // R3 short low pulse rejected
        wr(2'd2, 8'h00);
        hold(1'b0, 3 * TICK_DIV);
        hold(1'b1, 14 * BIT_CLKS);
        chk("R3 glitch ri", ri, 0);
        chk("R3 glitch byte", rx_byte, 8'hF7);
        send_frame(8'h81, 1'b0, 1'b1);
        chk("R3 recover byte", rx_byte, 8'h81);
        wr(2'd2, 8'h00);

        // R11 no ticks, no progress
        tick_run = 1'b0;
        send_frame(8'h42, 1'b0, 1'b1);
        chk("R11 ri", ri, 0);
        chk("R11 byte", rx_byte, 8'h81);
        tick_run = 1'b1;
        hold(1'b1, BIT_CLKS);

        // R7 / R9 framing error shown through view bit
        wr(2'd2, 8'h40);
        send_frame(8'h11, 1'b0, 1'b0);
        chk("R7 fe set", fe, 1);
        chk("R7 ri untouched", ri, 0);
        chk("R7 byte untouched", rx_byte, 8'h81);
        chk("R9 view fe", ctrl_top, 1);
        send_frame(8'h22, 1'b0, 1'b1);
        chk("R7 fe sticky", fe, 1);
        chk("R7 good frame ri", ri, 1);
        chk("R7 good frame byte", rx_byte, 8'h22);
        wr(2'd2, 8'h40);
        chk("R8 fe clear", fe, 0);
        chk("R8 ri clear2", ri, 0);

        // R9 mode bit view, write with select 0 leaves fe
        wr(2'd2, 8'h80);
        chk("R9 mode view", ctrl_top, 1);
        send_frame(8'h33, 1'b0, 1'b0);
        chk("R9 fe under mode view", fe, 1);
        chk("R9 top still mode", ctrl_top, 1);
        wr(2'd2, 8'h00);
        chk("R9 top mode0", ctrl_top, 0);
        chk("R9 fe unchanged", fe, 1);
        wr(2'd2, 8'h40);
        chk("R8 fe clear2", fe, 0);

        // R10 same-cycle set and clear of ri
        wr(2'd2, 8'h00);
        fork
            send_frame(8'h99, 1'b0, 1'b1);
            write_at_pending(8'h00);
        join
        chk("R10 ri set wins", ri, 1);
        chk("R10 byte", rx_byte, 8'h99);

        // R10 same-cycle set and clear of fe
        wr(2'd2, 8'h40);
        fork
            send_frame(8'h55, 1'b0, 1'b0);
            write_at_pending(8'h40);
        join
        chk("R10 fe set wins", fe, 1);

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule